// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a 32-bit physical address by walking a two-level page table held in memory. A translation request carries the logical address, a flag saying whether the access is a write and a flag saying whether it comes from user mode. The walker reads one entry from the primary table, whose base frame sits in a control register that the scheduler reloads on every process switch. The primary entry names the frame holding the secondary table, and the walker reads one entry from that table next. It then returns either the physical address or a page fault with a cause code.

Each table entry is 32 bits. Bit 0 is the present flag, bit 1 allows writes and bit 2 marks a user-space page (0 means system space). Bits [31:12] hold a 20-bit frame number. A table has 1024 entries and fills one 4 KiB frame. Permission is the AND of the write bits, and of the user bits, from both levels.

Every streaming interface uses valid/ready. A transfer happens on a clock edge where both are high. A source holds valid and its payload steady until the transfer. The walker serves one request at a time: the request port stays not-ready from acceptance until the response has been taken. Memory back-pressure on either the read request or the read data only adds cycles.

Top module: `ptw_top`

## Requirements
- R1: During and right after reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: The first memory read of a walk is at byte address {base frame, 12'b0} + 4 * vaddr[31:22]. The base frame is the one held in the control register when the request was accepted.
- R3: When the primary entry has bit 0 set, the second read is at {primary entry[31:12], 12'b0} + 4 * vaddr[21:12].
- R4: When the walk succeeds, rsp_paddr = {secondary entry[31:12], vaddr[11:0]} and rsp_cause = 0. For example, with secondary entry frame 0x00012, logical 0x08048ABC gives 0x00012ABC.
- R5: If bit 0 of the primary entry is 0, the response has cause 1 and rsp_paddr 0, and no second read is issued.
- R6: If bit 0 of the secondary entry is 0, the response has cause 2 and rsp_paddr 0.
- R7: A user-mode access faults with cause 4 when bit 2 is 0 in either entry. This cause takes priority over cause 3.
- R8: A write faults with cause 3 when bit 1 is 0 in either entry, in both modes. Reads of read-only pages succeed, and supervisor accesses to user pages succeed.
- R9: A write to the base port changes the primary table used by requests accepted after it, but not a walk already accepted. Bits [11:0] of the written value are ignored.
- R10: After a request is accepted, req_ready stays 0 until the response transfer. rsp_valid, rsp_paddr and rsp_cause hold steady while rsp_ready is 0.
- R11: A memory read request holds mem_req_valid and mem_req_addr until it is accepted. No new read is issued while one is waiting for its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load the primary table base register |
| base_wdata | input | 32 | New primary table base address (bits [11:0] ignored) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_cause | output | 3 | 0 ok, 1 primary absent, 2 secondary absent, 3 write protect, 4 privilege |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_ready | output | 1 | Walker takes the read data |
| mem_rsp_data | input | 32 | Table entry read from memory |

## Verification
The assertions assume that memory answers each accepted read with exactly one data beat. They also assume that it raises mem_rsp_valid only after a read has been accepted, and that the consumer and the memory obey the valid/ready holding rule. The bench memory model queues a single read and returns its data after a set latency. It can hold mem_req_ready low for several cycles. The requester keeps req_valid and the request fields steady until the transfer. The response side withholds rsp_ready for a chosen number of cycles, so the stability rules under back-pressure are exercised.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RD_PRI   = 2'd1,
    ST_RD_SEC   = 2'd2,
    ST_RESP     = 2'd3
  } walk_state_e;

  typedef enum logic [2:0] {
    CAUSE_NONE       = 3'd0,
    CAUSE_PRI_ABSENT = 3'd1,
    CAUSE_SEC_ABSENT = 3'd2,
    CAUSE_WRITE_PROT = 3'd3,
    CAUSE_PRIV       = 3'd4
  } fault_cause_e;

  // entry flag bit positions
  localparam int unsigned FLG_PRESENT = 0;
  localparam int unsigned FLG_WRITE   = 1;
  localparam int unsigned FLG_USER    = 2;

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [PA_W-1:0]         wr_data,
  output logic [PA_W-OFF_W-1:0]   frame_o
);

  localparam int unsigned FRAME_W = PA_W - OFF_W;

  logic [FRAME_W-1:0] frame_q;
  logic               unused_low_bits;

  assign unused_low_bits = ^wr_data[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (wr_en) begin
      frame_q <= wr_data[PA_W-1:OFF_W];
    end
  end

  assign frame_o = frame_q;

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic         sec_present,
  input  logic         pri_write_ok,
  input  logic         pri_user_ok,
  input  logic         sec_write_ok,
  input  logic         sec_user_ok,
  input  logic         acc_write,
  input  logic         acc_user,
  output fault_cause_e cause
);

  logic eff_write_ok;
  logic eff_user_ok;

  assign eff_write_ok = pri_write_ok & sec_write_ok;
  assign eff_user_ok  = pri_user_ok & sec_user_ok;

  // privilege is judged before write protection
  always_comb begin
    if (!sec_present) begin
      cause = CAUSE_SEC_ABSENT;
    end else if (acc_user && !eff_user_ok) begin
      cause = CAUSE_PRIV;
    end else if (acc_write && !eff_write_ok) begin
      cause = CAUSE_WRITE_PROT;
    end else begin
      cause = CAUSE_NONE;
    end
  end

endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned PRI_IDX_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PA_W-OFF_W-1:0]  base_frame,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_write,
  input  logic                   req_user,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [PA_W-1:0]        rsp_paddr,
  output logic [2:0]             rsp_cause,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [PA_W-1:0]        mem_req_addr,
  input  logic                   mem_rsp_valid,
  output logic                   mem_rsp_ready,
  input  logic [PA_W-1:0]        mem_rsp_data,
  output logic                   chk_sec_present,
  output logic                   chk_pri_write,
  output logic                   chk_pri_user,
  output logic                   chk_sec_write,
  output logic                   chk_sec_user,
  output logic                   chk_acc_write,
  output logic                   chk_acc_user,
  input  fault_cause_e           chk_cause
);

  localparam int unsigned FRAME_W   = PA_W - OFF_W;
  localparam int unsigned SEC_IDX_W = VA_W - OFF_W - PRI_IDX_W;
  localparam int unsigned PRI_LO    = OFF_W + SEC_IDX_W;
  localparam int unsigned ENT_LOG2  = $clog2(PA_W / 8);

  walk_state_e              state_q;
  logic                     issued_q;
  logic [VA_W-1:0]          va_q;
  logic                     wr_q;
  logic                     usr_q;
  logic [FRAME_W-1:0]       tbl_frame_q;
  logic [FRAME_W-1:0]       sec_frame_q;
  logic                     pri_wr_q;
  logic                     pri_us_q;
  logic [PA_W-1:0]          paddr_q;
  fault_cause_e             cause_q;

  logic [PRI_IDX_W-1:0]     pri_idx;
  logic [SEC_IDX_W-1:0]     sec_idx;
  logic [OFF_W-1:0]         page_off;
  logic                     reading;
  logic                     req_fire;
  logic                     mreq_fire;
  logic                     mrsp_fire;
  logic                     rsp_fire;
  logic                     unused_entry_bits;

  assign pri_idx  = va_q[VA_W-1:PRI_LO];
  assign sec_idx  = va_q[PRI_LO-1:OFF_W];
  assign page_off = va_q[OFF_W-1:0];

  assign unused_entry_bits = ^mem_rsp_data[OFF_W-1:FLG_USER+1];

  assign reading   = (state_q == ST_RD_PRI) || (state_q == ST_RD_SEC);
  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;

  assign mem_req_valid = reading && !issued_q;
  assign mem_rsp_ready = reading && issued_q;
  assign mreq_fire     = mem_req_valid && mem_req_ready;
  assign mrsp_fire     = mem_rsp_valid && mem_rsp_ready;

  always_comb begin
    if (state_q == ST_RD_SEC) begin
      mem_req_addr = {sec_frame_q, {OFF_W{1'b0}}} | (PA_W'(sec_idx) << ENT_LOG2);
    end else begin
      mem_req_addr = {tbl_frame_q, {OFF_W{1'b0}}} | (PA_W'(pri_idx) << ENT_LOG2);
    end
  end

  // operands for the permission checker
  assign chk_sec_present = mem_rsp_data[FLG_PRESENT];
  assign chk_sec_write   = mem_rsp_data[FLG_WRITE];
  assign chk_sec_user    = mem_rsp_data[FLG_USER];
  assign chk_pri_write   = pri_wr_q;
  assign chk_pri_user    = pri_us_q;
  assign chk_acc_write   = wr_q;
  assign chk_acc_user    = usr_q;

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign rsp_paddr = paddr_q;
  assign rsp_cause = cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      issued_q    <= 1'b0;
      va_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      tbl_frame_q <= '0;
      sec_frame_q <= '0;
      pri_wr_q    <= 1'b0;
      pri_us_q    <= 1'b0;
      paddr_q     <= '0;
      cause_q     <= CAUSE_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_fire) begin
            va_q        <= req_vaddr;
            wr_q        <= req_write;
            usr_q       <= req_user;
            tbl_frame_q <= base_frame;
            issued_q    <= 1'b0;
            state_q     <= ST_RD_PRI;
          end
        end
        ST_RD_PRI: begin
          if (mreq_fire) begin
            issued_q <= 1'b1;
          end
          if (mrsp_fire) begin
            issued_q <= 1'b0;
            if (!mem_rsp_data[FLG_PRESENT]) begin
              cause_q <= CAUSE_PRI_ABSENT;
              paddr_q <= '0;
              state_q <= ST_RESP;
            end else begin
              sec_frame_q <= mem_rsp_data[PA_W-1:OFF_W];
              pri_wr_q    <= mem_rsp_data[FLG_WRITE];
              pri_us_q    <= mem_rsp_data[FLG_USER];
              state_q     <= ST_RD_SEC;
            end
          end
        end
        ST_RD_SEC: begin
          if (mreq_fire) begin
            issued_q <= 1'b1;
          end
          if (mrsp_fire) begin
            issued_q <= 1'b0;
            cause_q  <= chk_cause;
            if (chk_cause == CAUSE_NONE) begin
              paddr_q <= {mem_rsp_data[PA_W-1:OFF_W], page_off};
            end else begin
              paddr_q <= '0;
            end
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_fire) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: once accepted, no second request until answered
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);

  // R10: response held under back-pressure
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause)));

  // R11: read request held until accepted
  a_r11_memreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R11: a single read outstanding
  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_fire |=> !mem_req_valid);

  // R5, R6: faults carry a zero address
  a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause != 3'd0) |-> (rsp_paddr == '0));

  // R7: privilege faults only for user-mode accesses
  a_r7_priv_needs_user: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == 3'd4) |-> usr_q);

  // R8: write-protection faults only for writes
  a_r8_wprot_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == 3'd3) |-> wr_q);

  // R5: a primary miss goes straight to the response
  a_r5_no_second_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_PRI && mrsp_fire && !mem_rsp_data[FLG_PRESENT]) |=> (rsp_valid && !mem_req_valid));

endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned PRI_IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [2:0]       rsp_cause,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [PA_W-1:0]  mem_rsp_data
);

  localparam int unsigned FRAME_W = PA_W - OFF_W;

  logic [FRAME_W-1:0] base_frame;
  logic               c_sec_present;
  logic               c_pri_write;
  logic               c_pri_user;
  logic               c_sec_write;
  logic               c_sec_user;
  logic               c_acc_write;
  logic               c_acc_user;
  fault_cause_e       c_cause;

  ptw_base_reg #(
    .PA_W  (PA_W),
    .OFF_W (OFF_W)
  ) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_we),
    .wr_data (base_wdata),
    .frame_o (base_frame)
  );

  ptw_perm_check u_perm (
    .sec_present  (c_sec_present),
    .pri_write_ok (c_pri_write),
    .pri_user_ok  (c_pri_user),
    .sec_write_ok (c_sec_write),
    .sec_user_ok  (c_sec_user),
    .acc_write    (c_acc_write),
    .acc_user     (c_acc_user),
    .cause        (c_cause)
  );

  ptw_walk_ctrl #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .OFF_W     (OFF_W),
    .PRI_IDX_W (PRI_IDX_W)
  ) u_walk (
    .clk             (clk),
    .rst_n           (rst_n),
    .base_frame      (base_frame),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_vaddr       (req_vaddr),
    .req_write       (req_write),
    .req_user        (req_user),
    .rsp_valid       (rsp_valid),
    .rsp_ready       (rsp_ready),
    .rsp_paddr       (rsp_paddr),
    .rsp_cause       (rsp_cause),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .mem_rsp_valid   (mem_rsp_valid),
    .mem_rsp_ready   (mem_rsp_ready),
    .mem_rsp_data    (mem_rsp_data),
    .chk_sec_present (c_sec_present),
    .chk_pri_write   (c_pri_write),
    .chk_pri_user    (c_pri_user),
    .chk_sec_write   (c_sec_write),
    .chk_sec_user    (c_sec_user),
    .chk_acc_write   (c_acc_write),
    .chk_acc_user    (c_acc_user),
    .chk_cause       (c_cause)
  );

  // R1: nothing is requested from memory without a pending translation
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rsp_valid));

  // R9: the base register follows its write port
  a_r9_base_load: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> (base_frame == $past(base_wdata[PA_W-1:OFF_W])));

endmodule

// File: tb/sim_ptw_top.sv
module sim_ptw_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_cause;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  ptw_top u0 (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_fail = 0;

  // memory model
  logic [31:0] mem_tbl [logic [31:0]];
  int          rsp_lat = 0;
  int          req_gap = 0;
  int          n_reads = 0;
  logic [31:0] rd_log [4];
  bit          pend = 0;
  logic [31:0] pend_addr = '0;
  int          lat_cnt = 0;
  int          req_wait = 0;
  bit          hs_req = 0;
  bit          hs_rsp = 0;
  logic [31:0] hs_addr = '0;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem_tbl.exists(a) ? mem_tbl[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 0; hs_req = 0; hs_rsp = 0; req_wait = 0;
      mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
    end else begin
      if (hs_req) begin
        pend = 1; pend_addr = hs_addr; lat_cnt = rsp_lat; req_wait = 0;
        if (n_reads < 4) rd_log[n_reads] = hs_addr;
        n_reads++;
      end
      if (hs_rsp) begin
        mem_rsp_valid = 1'b0; pend = 0;
      end
      if (pend && !mem_rsp_valid) begin
        if (lat_cnt == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = mem_rd(pend_addr);
        end else begin
          lat_cnt--;
        end
      end
      mem_req_ready = mem_req_valid && (req_wait >= req_gap);
      if (mem_req_valid && !mem_req_ready) req_wait++;
      hs_req  = mem_req_valid && mem_req_ready;
      hs_addr = mem_req_addr;
      hs_rsp  = mem_rsp_valid && mem_rsp_ready;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic write_base(input logic [31:0] v);
    @(negedge clk);
    base_we = 1'b1; base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  // one translation, checked against expected cause, address and reads
  task automatic xlate(input logic [31:0] va, input bit wr, input bit usr,
                       input logic [2:0] exp_cause, input logic [31:0] exp_pa,
                       input int exp_reads, input logic [31:0] exp_a0, input logic [31:0] exp_a1,
                       input int hold, input bit mid_base, input logic [31:0] mid_val,
                       input string tag);
    logic [31:0] pa_seen;
    logic [2:0]  cause_seen;
    int          wait_cnt;
    n_reads = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    wait_cnt = 0;
    while (!req_ready && wait_cnt < 1000) begin @(negedge clk); wait_cnt++; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, {tag, " R10 busy after accept"}, 32'(req_ready), 32'h0);
    if (mid_base) begin
      base_we = 1'b1; base_wdata = mid_val;
      @(negedge clk);
      base_we = 1'b0;
    end
    wait_cnt = 0;
    while (!rsp_valid && wait_cnt < 1000) begin @(negedge clk); wait_cnt++; end
    pa_seen = rsp_paddr; cause_seen = rsp_cause;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa_seen && rsp_cause == cause_seen,
          {tag, " R10 response held"}, rsp_paddr, pa_seen);
      chk(!req_ready, {tag, " R10 no accept while answering"}, 32'(req_ready), 32'h0);
    end
    chk(rsp_cause == exp_cause, {tag, " cause"}, 32'(rsp_cause), 32'(exp_cause));
    chk(rsp_paddr == exp_pa, {tag, " paddr"}, rsp_paddr, exp_pa);
    chk(n_reads == exp_reads, {tag, " read count"}, 32'(n_reads), 32'(exp_reads));
    if (exp_reads >= 1) chk(rd_log[0] == exp_a0, {tag, " R2 primary address"}, rd_log[0], exp_a0);
    if (exp_reads >= 2) chk(rd_log[1] == exp_a1, {tag, " R3 secondary address"}, rd_log[1], exp_a1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, {tag, " R10 released"}, 32'(rsp_valid), 32'h0);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 req_ready in reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid in reset", 32'(mem_req_valid), 32'h0);
  endtask

  task automatic t_basic;
    rsp_lat = 0; req_gap = 0;
    xlate(32'h08048ABC, 0, 1, 3'd0, 32'h00012ABC, 2, 32'h00100080, 32'h00200120, 0, 0, 0, "R4 basic");
    xlate(32'h08048000, 1, 1, 3'd0, 32'h00012000, 2, 32'h00100080, 32'h00200120, 0, 0, 0, "R4 low offset");
  endtask

  task automatic t_backpressure;
    rsp_lat = 3; req_gap = 2;
    xlate(32'h08048FFF, 0, 0, 3'd0, 32'h00012FFF, 2, 32'h00100080, 32'h00200120, 3, 0, 0, "R11 stalled memory");
    rsp_lat = 0; req_gap = 0;
  endtask

  task automatic t_absent;
    xlate(32'h40000123, 0, 0, 3'd1, 32'h0, 1, 32'h00100400, 32'h0, 1, 0, 0, "R5 primary absent");
    xlate(32'h08049010, 0, 1, 3'd2, 32'h0, 2, 32'h00100080, 32'h00200124, 0, 0, 0, "R6 secondary absent");
  endtask

  task automatic t_perm;
    xlate(32'h0804A004, 0, 1, 3'd4, 32'h0, 2, 32'h00100080, 32'h00200128, 0, 0, 0, "R7 user to system page");
    xlate(32'h0804A004, 1, 0, 3'd0, 32'h00013004, 2, 32'h00100080, 32'h00200128, 0, 0, 0, "R8 supervisor to system page");
    xlate(32'h0804B008, 1, 1, 3'd3, 32'h0, 2, 32'h00100080, 32'h0020012C, 0, 0, 0, "R8 user write read-only");
    xlate(32'h0804B008, 0, 1, 3'd0, 32'h00014008, 2, 32'h00100080, 32'h0020012C, 0, 0, 0, "R8 user read read-only");
    xlate(32'h0804B008, 1, 0, 3'd3, 32'h0, 2, 32'h00100080, 32'h0020012C, 0, 0, 0, "R8 supervisor write read-only");
    xlate(32'h08400010, 0, 1, 3'd4, 32'h0, 2, 32'h00100084, 32'h00300000, 0, 0, 0, "R7 primary system level");
    xlate(32'h08400010, 1, 0, 3'd0, 32'h00015010, 2, 32'h00100084, 32'h00300000, 0, 0, 0, "R8 supervisor write via system primary");
    xlate(32'h08800020, 1, 1, 3'd3, 32'h0, 2, 32'h00100088, 32'h00400000, 0, 0, 0, "R8 primary read-only");
    xlate(32'h08800020, 0, 1, 3'd0, 32'h00016020, 2, 32'h00100088, 32'h00400000, 0, 0, 0, "R8 read via read-only primary");
    xlate(32'h0804C000, 1, 1, 3'd4, 32'h0, 2, 32'h00100080, 32'h00200130, 0, 0, 0, "R7 priority over write");
  endtask

  task automatic t_switch;
    write_base(32'h00500FFF);
    xlate(32'h08048ABC, 0, 1, 3'd0, 32'h00099ABC, 2, 32'h00500080, 32'h00600120, 0, 0, 0, "R9 switched base");
    req_gap = 3;
    xlate(32'h08048ABC, 0, 1, 3'd0, 32'h00099ABC, 2, 32'h00500080, 32'h00600120, 0, 1, 32'h00100000, "R9 base write mid-walk");
    req_gap = 0;
    xlate(32'h08048ABC, 0, 1, 3'd0, 32'h00012ABC, 2, 32'h00100080, 32'h00200120, 0, 0, 0, "R9 new base after walk");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    mem_tbl[32'h00100080] = 32'h00200007;
    mem_tbl[32'h00100084] = 32'h00300003;
    mem_tbl[32'h00100088] = 32'h00400005;
    mem_tbl[32'h00200120] = 32'h00012007;
    mem_tbl[32'h00200128] = 32'h00013003;
    mem_tbl[32'h0020012C] = 32'h00014005;
    mem_tbl[32'h00200130] = 32'h00017001;
    mem_tbl[32'h00300000] = 32'h00015007;
    mem_tbl[32'h00400000] = 32'h00016007;
    mem_tbl[32'h00500080] = 32'h00600007;
    mem_tbl[32'h00600120] = 32'h00099007;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    write_base(32'h00100000);
    t_basic();
    t_backpressure();
    t_absent();
    t_perm();
    t_switch();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule